// File: doc/BRIEF.md
# Link BIST Pattern Checker

This block sits on the receive side of an 8b/10b serial link, after the character decoder. When its active-low test enable is pulled low, it hunts for an initialization special character. Once that character arrives it generates the expected test pattern locally and compares every received character against it. The pattern is a loop of 255 pseudo-random data bytes followed by one marker special character. Each comparison result is reported on a registered per-character error output. A ready output marks both synchronization and the end of every loop, so an external counter can follow progress.

Each loop carries three deliberate code violations. At those positions the error output must pulse, which proves that violation reporting works end to end. While the checker is enabled, the byte and special-flag outputs show the expected pattern instead of the received data, which helps with debugging. A path-select output forces the receiver into decoded operation during test, even when the raw-bypass mode is selected. All checker state advances only on the character strobe.

Top module: `link_bist_checker`

## Requirements
- R1: `decode_sel` is 1 (decoded path) whenever `bist_en_n` is 0 or `raw_mode` is 0. It is 0 only when `raw_mode` is 1 and `bist_en_n` is 1.
- R2: After reset, with `bist_en_n` high, `bist_err` and `bist_rdy` are 0.
- R3: A clock with `bist_en_n` high returns the checker to idle. From the next clock on, `bist_err` is 0, and `bist_rdy` is 0 for as long as `bist_en_n` stays high.
- R4: While enabled and not yet synchronized, `bist_rdy` is 1. A strobed character with `rx_special`=1, `rx_viol`=0 and `rx_data`=0xBC synchronizes the checker. From the clock of that strobe on, `bist_rdy` is 0 and comparison starts at loop position 0.
- R5: Loop positions 0 to 254 expect data characters equal to an 8-bit LFSR state. The LFSR is seeded with 0x01 at position 0. Each step shifts left and makes the new bit 0 the XOR of bits 7, 5, 4 and 3. Position 255 expects the special character 0xFC. After position 255 the loop restarts at position 0 with the seed.
- R6: At a non-violation position, the character is a mismatch if its data differs from the expected byte, if its special flag differs from the expected flag, or if `rx_viol` is 1. The character's error result appears on `bist_err` from the clock of its strobe and holds until the next strobe.
- R7: Positions 63, 127 and 191 expect a code violation. `bist_err` is 1 for those characters whether or not `rx_viol` is 1.
- R8: For the character at position 255, `bist_rdy` is 1 from its strobe until the next strobe, which gives exactly one ready pulse per loop.
- R9: While `bist_en_n` is low and the checker is synchronized, `out_data` and `out_special` show the character expected at the next position. While `bist_en_n` is high they pass `rx_data` and `rx_special` through.
- R10: Clocks without `chr_stb` change no output except through `bist_en_n`.
- R11: Characters received before synchronization never raise `bist_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chr_stb | input | 1 | One decoded character is present this clock |
| bist_en_n | input | 1 | Active-low self-test enable |
| raw_mode | input | 1 | 1 selects raw bypass of the decoder in normal operation |
| rx_data | input | 8 | Decoded byte |
| rx_special | input | 1 | Decoded character is a special character |
| rx_viol | input | 1 | Decoder flagged a code violation |
| out_data | output | 8 | Expected byte while enabled, otherwise `rx_data` |
| out_special | output | 1 | Expected special flag while enabled, otherwise `rx_special` |
| bist_err | output | 1 | Registered per-character mismatch flag |
| bist_rdy | output | 1 | High while hunting, and pulses high at the end of each loop |
| decode_sel | output | 1 | 1 selects the decoded receive path |

## Verification
The properties assume that `chr_stb` is the only event that moves checker state, and that `bist_en_n` is a level that may change on any clock. They therefore tie every edge of `bist_rdy` and every change of `bist_err` to a strobe or to the enable. The stimulus drives all inputs at the falling clock edge and holds each strobe for a single clock, so every character is sampled exactly once. Random gaps between characters, random corruption of data, special flag and violation bits, and enable drops in the middle of a loop all stay inside that assumption.

// File: rtl/link_bist_pkg.sv
package link_bist_pkg;

  parameter int unsigned BYTE_W = 8;

  // Expected character at the current loop position
  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              special;
    logic              viol_slot;
    logic              loop_end;
  } bist_exp_t;

endpackage

// File: rtl/bist_lfsr.sv
module bist_lfsr #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h01
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] q
);

  logic [W-1:0] q_q;
  logic [W-1:0] q_d;
  logic         fb;

  assign fb = ^(q_q & TAPS);

  always_comb begin
    q_d = q_q;
    if (load) begin
      q_d = SEED;
    end else if (step) begin
      q_d = {q_q[W-2:0], fb};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= SEED;
    end else if (load || step) begin
      q_q <= q_d;
    end
  end

  assign q = q_q;

endmodule

// File: rtl/bist_pattern_gen.sv
module bist_pattern_gen
  import link_bist_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SEED      = 8'h01,
  parameter logic [BYTE_W-1:0] TAPS      = 8'hB8,
  parameter logic [BYTE_W-1:0] MARKER    = 8'hFC,
  parameter int unsigned       VIOL_LOG2 = 6
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      restart,
  input  logic      advance,
  output bist_exp_t exp_o
);

  logic [BYTE_W-1:0] pos_q;
  logic [BYTE_W-1:0] pos_d;
  logic [BYTE_W-1:0] lfsr_q;
  logic              at_end;
  logic              at_viol;

  assign at_end  = &pos_q;
  assign at_viol = (&pos_q[VIOL_LOG2-1:0]) & ~at_end;

  always_comb begin
    pos_d = pos_q;
    if (restart) begin
      pos_d = '0;
    end else if (advance) begin
      pos_d = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (restart || advance) begin
      pos_q <= pos_d;
    end
  end

  bist_lfsr #(
    .W    (BYTE_W),
    .TAPS (TAPS),
    .SEED (SEED)
  ) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (restart | (advance & at_end)),
    .step  (advance & ~at_end),
    .q     (lfsr_q)
  );

  always_comb begin
    exp_o.data      = at_end ? MARKER : lfsr_q;
    exp_o.special   = at_end;
    exp_o.viol_slot = at_viol;
    exp_o.loop_end  = at_end;
  end

endmodule

// File: rtl/bist_compare.sv
module bist_compare
  import link_bist_pkg::*;
(
  input  bist_exp_t         exp_i,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_special,
  input  logic              rx_viol,
  output logic              err_now
);

  logic data_miss;
  logic viol_miss;

  always_comb begin
    data_miss = rx_viol
              | (rx_special != exp_i.special)
              | (rx_data != exp_i.data);
    // a missing violation is a mismatch, a present one is reported
    viol_miss = ~rx_viol;
    err_now   = exp_i.viol_slot ? (viol_miss | rx_viol) : data_miss;
  end

endmodule

// File: rtl/link_bist_checker.sv
module link_bist_checker
  import link_bist_pkg::*;
#(
  parameter logic [BYTE_W-1:0] INIT_CODE = 8'hBC,
  parameter logic [BYTE_W-1:0] MARKER    = 8'hFC,
  parameter logic [BYTE_W-1:0] SEED      = 8'h01,
  parameter logic [BYTE_W-1:0] TAPS      = 8'hB8,
  parameter int unsigned       VIOL_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chr_stb,
  input  logic              bist_en_n,
  input  logic              raw_mode,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_special,
  input  logic              rx_viol,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_special,
  output logic              bist_err,
  output logic              bist_rdy,
  output logic              decode_sel
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_s_n = rst_pipe_q[SYNC_STAGES-1];

  logic      run_q, run_d;
  logic      err_q, err_d;
  logic      pulse_q, pulse_d;
  logic      init_hit;
  logic      restart;
  logic      advance;
  logic      err_now;
  bist_exp_t exp_cur;

  assign init_hit = chr_stb & rx_special & ~rx_viol & (rx_data == INIT_CODE);
  assign restart  = ~bist_en_n & ~run_q & init_hit;
  assign advance  = ~bist_en_n & run_q & chr_stb;

  bist_pattern_gen #(
    .SEED      (SEED),
    .TAPS      (TAPS),
    .MARKER    (MARKER),
    .VIOL_LOG2 (VIOL_LOG2)
  ) u_gen (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .restart (restart),
    .advance (advance),
    .exp_o   (exp_cur)
  );

  bist_compare u_cmp (
    .exp_i      (exp_cur),
    .rx_data    (rx_data),
    .rx_special (rx_special),
    .rx_viol    (rx_viol),
    .err_now    (err_now)
  );

  always_comb begin
    run_d   = run_q;
    err_d   = err_q;
    pulse_d = pulse_q;
    if (bist_en_n) begin
      run_d   = 1'b0;
      err_d   = 1'b0;
      pulse_d = 1'b0;
    end else if (chr_stb) begin
      if (run_q) begin
        err_d   = err_now;
        pulse_d = exp_cur.loop_end;
      end else begin
        run_d   = init_hit;
        err_d   = 1'b0;
        pulse_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      run_q   <= 1'b0;
      err_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else if (bist_en_n || chr_stb) begin
      run_q   <= run_d;
      err_q   <= err_d;
      pulse_q <= pulse_d;
    end
  end

  assign bist_err    = err_q;
  assign bist_rdy    = ~bist_en_n & (~run_q | pulse_q);
  assign out_data    = bist_en_n ? rx_data : exp_cur.data;
  assign out_special = bist_en_n ? rx_special : exp_cur.special;
  assign decode_sel  = ~raw_mode | ~bist_en_n;

endmodule

// File: rtl/link_bist_checker_sva.sv
module link_bist_checker_sva (
  input logic clk,
  input logic rst_n,
  input logic chr_stb,
  input logic bist_en_n,
  input logic bist_err,
  input logic bist_rdy
);

  // R3
  disable_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bist_en_n |=> !bist_err);

  // R10
  err_holds_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chr_stb && !bist_en_n) |=> $stable(bist_err));

  // R4
  rdy_fall_on_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bist_rdy) && !bist_en_n) |-> $past(chr_stb));

  // R8
  rdy_rise_on_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bist_rdy) && !bist_en_n && $past(!bist_en_n)) |-> $past(chr_stb));

  // R3
  rdy_low_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bist_en_n |-> !bist_rdy);

endmodule

bind link_bist_checker link_bist_checker_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .chr_stb   (chr_stb),
  .bist_en_n (bist_en_n),
  .bist_err  (bist_err),
  .bist_rdy  (bist_rdy)
);

// File: tb/sim_link_bist_checker.sv
module sim_link_bist_checker;

  localparam logic [7:0] INIT = 8'hBC;
  localparam logic [7:0] MARK = 8'hFC;
  localparam logic [7:0] SEED = 8'h01;

  logic       clk = 1'b0;
  logic       rst_n, chr_stb, bist_en_n, raw_mode, rx_special, rx_viol;
  logic [7:0] rx_data;
  logic [7:0] out_data;
  logic       out_special, bist_err, bist_rdy, decode_sel;

  always #5 clk = ~clk;

  link_bist_checker u0 (
    .clk(clk), .rst_n(rst_n), .chr_stb(chr_stb), .bist_en_n(bist_en_n),
    .raw_mode(raw_mode), .rx_data(rx_data), .rx_special(rx_special),
    .rx_viol(rx_viol), .out_data(out_data), .out_special(out_special),
    .bist_err(bist_err), .bist_rdy(bist_rdy), .decode_sel(decode_sel)
  );

  int   checks = 0;
  int   fails  = 0;
  int   mpos   = 0;
  logic [7:0] mlfsr = SEED;
  bit   mrun = 0;
  bit   e_err = 0;
  bit   e_pulse = 0;
  int   rdy_pulses = 0;

  function automatic logic [7:0] lfsr_next(logic [7:0] q);
    return {q[6:0], q[7] ^ q[5] ^ q[4] ^ q[3]};
  endfunction

  function automatic bit is_viol_slot(int p);
    return (p == 63) || (p == 127) || (p == 191);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_outs(string req);
    bit e_rdy;
    e_rdy = bist_en_n ? 1'b0 : (mrun ? e_pulse : 1'b1);
    chk(bist_err == e_err, req, "bist_err", bist_err, e_err);
    chk(bist_rdy == e_rdy, req, "bist_rdy", bist_rdy, e_rdy);
    if (bist_en_n) begin
      chk(out_data == rx_data, "R9", "out_data pass", out_data, rx_data);
    end else if (mrun) begin
      chk(out_data == ((mpos == 255) ? MARK : mlfsr), "R9", "out_data exp",
          out_data, (mpos == 255) ? MARK : mlfsr);
      chk(out_special == (mpos == 255), "R9", "out_special exp",
          out_special, (mpos == 255));
    end
  endtask

  task automatic send(logic [7:0] d, bit s, bit v, string req);
    @(negedge clk);
    rx_data = d; rx_special = s; rx_viol = v; chr_stb = 1'b1;
    @(negedge clk);
    chr_stb = 1'b0;
    if (bist_en_n) begin
      mrun = 0; e_err = 0; e_pulse = 0;
    end else if (!mrun) begin
      e_err = 0; e_pulse = 0;
      if (s && !v && d == INIT) begin
        mrun = 1; mpos = 0; mlfsr = SEED;
      end
    end else begin
      if (is_viol_slot(mpos)) e_err = 1;
      else e_err = v || (s != (mpos == 255)) || (d != ((mpos == 255) ? MARK : mlfsr));
      e_pulse = (mpos == 255);
      if (mpos == 255) begin
        mpos = 0; mlfsr = SEED;
      end else begin
        mpos++; mlfsr = lfsr_next(mlfsr);
      end
    end
    check_outs(req);
    if (bist_rdy && mrun) rdy_pulses++;
  endtask

  task automatic gap(int n);
    repeat (n) @(negedge clk);
    check_outs("R10");
  endtask

  // sends the correct next character, optionally corrupted
  task automatic next_char(int corrupt_pct, bit allow_gaps);
    logic [7:0] d; bit s, v; string req; int r;
    if (!mrun) begin
      d = INIT; s = 1; v = 0; req = "R4";
    end else if (mpos == 255) begin
      d = MARK; s = 1; v = 0; req = "R8";
    end else if (is_viol_slot(mpos)) begin
      d = 8'($urandom); s = 0; v = ($urandom_range(0, 3) != 0); req = "R7";
    end else begin
      d = mlfsr; s = 0; v = 0; req = "R5";
    end
    if (mrun && !is_viol_slot(mpos) && $urandom_range(0, 99) < corrupt_pct) begin
      r = $urandom_range(0, 2);
      if (r == 0) d = d ^ (8'h01 << $urandom_range(0, 7));
      else if (r == 1) s = ~s;
      else v = 1;
      req = "R6";
    end
    send(d, s, v, req);
    if (allow_gaps && $urandom_range(0, 7) == 0) gap($urandom_range(1, 3));
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; chr_stb = 0; bist_en_n = 1; raw_mode = 1;
    rx_data = 8'h5A; rx_special = 0; rx_viol = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(bist_err == 0, "R2", "bist_err after reset", bist_err, 0);
    chk(bist_rdy == 0, "R2", "bist_rdy after reset", bist_rdy, 0);
    chk(decode_sel == 0, "R1", "decode_sel raw off", decode_sel, 0);
    chk(out_data == rx_data, "R9", "out_data disabled", out_data, rx_data);
    raw_mode = 0;
    @(negedge clk);
    chk(decode_sel == 1, "R1", "decode_sel decoded", decode_sel, 1);
    raw_mode = 1; bist_en_n = 0;
    @(negedge clk);
    chk(decode_sel == 1, "R1", "decode_sel forced", decode_sel, 1);
    chk(bist_rdy == 1, "R4", "bist_rdy hunting", bist_rdy, 1);

    // pre-sync traffic, including near misses of the init character
    send(INIT, 1'b0, 1'b0, "R11");
    send(INIT, 1'b1, 1'b1, "R11");
    send(8'hBD, 1'b1, 1'b0, "R11");
    for (int i = 0; i < 20; i++) send(8'($urandom), 1'b0, bit'($urandom), "R11");
    gap(2);

    send(INIT, 1'b1, 1'b0, "R4");
    chk(bist_rdy == 0, "R4", "bist_rdy after init", bist_rdy, 0);

    // two loops with random corruption and gaps
    for (int i = 0; i < 520; i++) next_char(8, 1'b1);

    // drop enable mid-loop
    @(negedge clk);
    bist_en_n = 1; rx_data = 8'h33; rx_special = 1;
    mrun = 0; e_err = 0; e_pulse = 0;
    @(negedge clk);
    check_outs("R3");
    chk(out_special == rx_special, "R9", "out_special pass", out_special, rx_special);
    bist_en_n = 0;
    @(negedge clk);
    check_outs("R3");

    // clean loop: exactly one ready pulse, errors only at violation slots
    send(INIT, 1'b1, 1'b0, "R4");
    rdy_pulses = 0;
    for (int i = 0; i < 256; i++) next_char(0, 1'b0);
    chk(rdy_pulses == 1, "R8", "ready pulses per loop", rdy_pulses, 1);
    // restart from seed after the loop
    chk(out_data == SEED, "R5", "seed after loop", out_data, SEED);
    send(SEED, 1'b0, 1'b0, "R5");
    chk(bist_err == 0, "R5", "first byte of new loop", bist_err, 0);

    $display("CHECKS %0d ERRORS %0d", checks, fails);
    $finish;
  end

endmodule